// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches the raw bit stream recovered from a DS3 or E3 line, before any zero-substitution decoding, and raises a loss-of-signal alarm. A run of consecutive zeros of programmable length sets the alarm on the very cycle the run completes. No further integration is applied.

Clearing is deliberately harder. Once the alarm is up, the block cuts time into back-to-back, non-overlapping windows of a fixed number of clock cycles and counts the ones in each window. The alarm drops at the end of the first window whose ones count exceeds a limit, and that limit depends on the line mode. A one-cycle change pulse marks every set and every clear, so that software can take an interrupt or log the transition.

Gating the clear on frame recovery is left to software.

Top module: `los_line_monitor`

## Requirements
- R1: With the alarm low, the alarm is high after the clock edge that samples the ZERO_RUN-th consecutive zero (default 175; legal 100 to 250). After ZERO_RUN-1 consecutive zeros it is still low.
- R2: A sampled one restarts the zero run, so ZERO_RUN further zeros are needed before the alarm sets.
- R3: While the alarm is high, it can fall only at the last cycle of a window. Windows are WIN_LEN cycles long (default 175). The first window starts on the first cycle the alarm is high, and each later window starts right after the previous one ends.
- R4: With mode_e3 = 0 (DS3), the alarm clears at a window end if the window held more than 57 ones. With 57 or fewer ones it stays set; 44 ones, for example, do not clear it.
- R5: With mode_e3 = 1 (E3), the alarm clears at a window end if the window held more than 43 ones. With 43 or fewer ones it stays set.
- R6: los_change is high for exactly the one cycle in which los_alarm shows a new value (a set or a clear), and low at all other times.
- R7: After reset, los_alarm and los_change are low and both the zero run and the window counts are zero. A run of zeros that started before reset does not count toward ZERO_RUN.
- R8: While the alarm is high, further runs of zeros are ignored: they produce no change pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_bit | input | 1 | Raw received line bit, before B3ZS/HDB3 decoding |
| mode_e3 | input | 1 | 0 selects DS3 clear limit, 1 selects E3 clear limit |
| los_alarm | output | 1 | Loss-of-signal alarm |
| los_change | output | 1 | One-cycle pulse on every alarm set or clear |

## Verification
The bench builds the block with its default parameters: a 175-zero run and 175-cycle windows, with limits of 57 and 43. These values let it hit each boundary exactly. It checks that 174 zeros do not set the alarm while 175 do. In DS3 mode it checks that windows with 44 and 57 ones keep the alarm up while 58 ones clear it. In E3 mode it checks the same pair at 43 and 44 ones. All of these finish in a few thousand cycles. The ones are placed at the end of each window, so a clear can only come from the window total and never from a count part-way through the window.

// File: rtl/los_pkg.sv
package los_pkg;

    // Registered alarm state of the top module
    typedef struct packed {
        logic alarm;
        logic change;
    } los_state_t;

endpackage

// File: rtl/zero_run_tracker.sv
module zero_run_tracker #(
    parameter int ZERO_RUN = 175
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    output logic run_hit
);
    localparam int ZW = $clog2(ZERO_RUN + 1);
    localparam logic [ZW-1:0] RUN_LAST = ZW'(ZERO_RUN - 1);
    localparam logic [ZW-1:0] RUN_TOP  = ZW'(ZERO_RUN);

    typedef struct packed {
        logic [ZW-1:0] zrun;
    } run_t;

    run_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_bit) begin
            st_d.zrun = '0;
        end else if (st_q.zrun != RUN_TOP) begin
            st_d.zrun = st_q.zrun + 1'b1;
        end
    end

    // High in the cycle that carries the final zero of a full run
    assign run_hit = !line_bit && (st_q.zrun >= RUN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/density_window.sv
module density_window #(
    parameter int WIN_LEN   = 175,
    parameter int DS3_LIMIT = 57,
    parameter int E3_LIMIT  = 43
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic line_bit,
    input  logic mode_e3,
    output logic clear_ok
);
    localparam int WW = $clog2(WIN_LEN + 1);
    localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
    localparam logic [WW-1:0] LIM_DS3  = WW'(DS3_LIMIT);
    localparam logic [WW-1:0] LIM_E3   = WW'(E3_LIMIT);

    typedef struct packed {
        logic [WW-1:0] cnt;
        logic [WW-1:0] ones;
    } win_t;

    win_t st_d, st_q;
    logic [WW-1:0] ones_now;
    logic [WW-1:0] limit;
    logic          at_end;

    always_comb begin
        ones_now = st_q.ones + WW'(line_bit);
        limit    = mode_e3 ? LIM_E3 : LIM_DS3;
        at_end   = (st_q.cnt == WIN_LAST);
        clear_ok = active && at_end && (ones_now > limit);

        st_d = st_q;
        if (!active || at_end) begin
            st_d.cnt  = '0;
            st_d.ones = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.ones = ones_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/los_line_monitor.sv
module los_line_monitor #(
    parameter int ZERO_RUN  = 175,
    parameter int WIN_LEN   = 175,
    parameter int DS3_LIMIT = 57,
    parameter int E3_LIMIT  = 43
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_bit,
    input  logic mode_e3,
    output logic los_alarm,
    output logic los_change
);
    import los_pkg::*;

    los_state_t st_d, st_q;
    logic run_hit;
    logic clear_ok;

    zero_run_tracker #(.ZERO_RUN(ZERO_RUN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_bit (line_bit),
        .run_hit  (run_hit)
    );

    density_window #(
        .WIN_LEN   (WIN_LEN),
        .DS3_LIMIT (DS3_LIMIT),
        .E3_LIMIT  (E3_LIMIT)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st_q.alarm),
        .line_bit (line_bit),
        .mode_e3  (mode_e3),
        .clear_ok (clear_ok)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.alarm && run_hit) begin
            st_d.alarm = 1'b1;
        end else if (st_q.alarm && clear_ok) begin
            st_d.alarm = 1'b0;
        end
        st_d.change = (st_d.alarm != st_q.alarm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign los_alarm  = st_q.alarm;
    assign los_change = st_q.change;
endmodule

// File: rtl/los_line_monitor_chk.sv
module los_line_monitor_chk #(
    parameter int ZERO_RUN = 175,
    parameter int WIN_LEN  = 175
) (
    input logic clk,
    input logic rst_n,
    input logic line_bit,
    input logic los_alarm,
    input logic los_change
);
    localparam int ZW = $clog2(ZERO_RUN + 1);
    localparam int WW = $clog2(WIN_LEN + 1);
    localparam logic [ZW-1:0] Z_LAST = ZW'(ZERO_RUN - 1);
    localparam logic [ZW-1:0] Z_TOP  = ZW'(ZERO_RUN);
    localparam logic [WW-1:0] W_LAST = WW'(WIN_LEN - 1);

    logic [ZW-1:0] zc_q;
    logic [WW-1:0] wc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zc_q <= '0;
            wc_q <= '0;
        end else begin
            if (line_bit)          zc_q <= '0;
            else if (zc_q != Z_TOP) zc_q <= zc_q + 1'b1;
            if (!los_alarm || wc_q == W_LAST) wc_q <= '0;
            else                              wc_q <= wc_q + 1'b1;
        end
    end

    // R1
    run_sets_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_alarm && !line_bit && zc_q >= Z_LAST) |=> los_alarm);

    // R2
    no_early_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_alarm && (line_bit || zc_q < Z_LAST)) |=> !los_alarm);

    // R3
    clear_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los_alarm && wc_q != W_LAST) |=> los_alarm);

    // R6
    pulse_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los_alarm != $past(los_alarm)) |-> los_change);

    // R6
    pulse_only_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        los_change |-> (los_alarm != $past(los_alarm)));

    // R7
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!los_alarm && !los_change);
        end
    end
endmodule

bind los_line_monitor los_line_monitor_chk #(
    .ZERO_RUN (ZERO_RUN),
    .WIN_LEN  (WIN_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_bit   (line_bit),
    .los_alarm  (los_alarm),
    .los_change (los_change)
);

// File: tb/tb_los_line_monitor.sv
module tb_los_line_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int ZRUN = 175;
    localparam int WIN  = 175;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_bit = 1'b0;
    logic mode_e3 = 1'b0;
    logic los_alarm, los_change;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    los_line_monitor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_bit   (line_bit),
        .mode_e3    (mode_e3),
        .los_alarm  (los_alarm),
        .los_change (los_change)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic drive(input logic b);
        line_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        line_bit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // Drive all but the last bit of a window: zeros first, then n-1 ones.
    // Returns the number of change pulses seen along the way.
    task automatic window_body(input int n_ones, output int pulses);
        pulses = 0;
        for (int i = 0; i < WIN - 1; i++) begin
            drive(i >= WIN - n_ones);
            if (los_change) pulses++;
        end
    endtask

    task automatic enter_alarm();
        for (int i = 0; i < ZRUN; i++) drive(1'b0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R7 alarm low after reset", los_alarm, 1'b0);
        check("R7 change low after reset", los_change, 1'b0);
    endtask

    task automatic t_run_threshold();
        do_reset();
        for (int i = 0; i < ZRUN - 1; i++) drive(1'b0);
        check("R1 no alarm at run-1", los_alarm, 1'b0);
        drive(1'b1);
        for (int i = 0; i < ZRUN - 1; i++) drive(1'b0);
        check("R2 one restarts run", los_alarm, 1'b0);
        drive(1'b0);
        check("R1 alarm at full run", los_alarm, 1'b1);
        check("R6 pulse on set", los_change, 1'b1);
        drive(1'b0);
        check("R6 pulse lasts one cycle", los_change, 1'b0);
        check("R8 alarm holds under zeros", los_alarm, 1'b1);
    endtask

    task automatic t_reset_mid_run();
        do_reset();
        for (int i = 0; i < 100; i++) drive(1'b0);
        do_reset();
        for (int i = 0; i < ZRUN - 1; i++) drive(1'b0);
        check("R7 run cleared by reset", los_alarm, 1'b0);
        drive(1'b0);
        check("R7 full run after reset sets", los_alarm, 1'b1);
    endtask

    task automatic t_ds3_clear();
        int p;
        do_reset();
        mode_e3 = 1'b0;
        enter_alarm();
        check("R1 alarm up for DS3 test", los_alarm, 1'b1);
        window_body(44, p);
        drive(1'b1);
        check("R4 DS3 44 ones keep alarm", los_alarm, 1'b1);
        check("R8 no pulse in window", p != 0, 1'b0);
        window_body(57, p);
        drive(1'b1);
        check("R4 DS3 57 ones keep alarm", los_alarm, 1'b1);
        check("R6 no pulse without clear", los_change, 1'b0);
        window_body(58, p);
        check("R3 no clear before window end", los_alarm, 1'b1);
        drive(1'b1);
        check("R4 DS3 58 ones clear alarm", los_alarm, 1'b0);
        check("R6 pulse on clear", los_change, 1'b1);
        drive(1'b1);
        check("R6 clear pulse one cycle", los_change, 1'b0);
    endtask

    task automatic t_e3_clear();
        int p;
        do_reset();
        mode_e3 = 1'b1;
        enter_alarm();
        check("R1 alarm up for E3 test", los_alarm, 1'b1);
        window_body(43, p);
        drive(1'b1);
        check("R5 E3 43 ones keep alarm", los_alarm, 1'b1);
        check("R8 no pulse in E3 window", p != 0, 1'b0);
        window_body(44, p);
        check("R3 E3 no clear before end", los_alarm, 1'b1);
        drive(1'b1);
        check("R5 E3 44 ones clear alarm", los_alarm, 1'b0);
        check("R6 pulse on E3 clear", los_change, 1'b1);
        mode_e3 = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_run_threshold();
        t_reset_mid_run();
        t_ds3_clear();
        t_e3_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule